// File: doc/BRIEF.md
# Bit-Sliced Ripple Arithmetic/Logic Unit

This block is a purely combinational integer datapath unit. It is built from a column of identical one-bit cells, each of which forms the AND, the OR and a full-adder sum of its operand bits all the time. A per-cell selector then chooses which of these reaches the result. Each cell's carry output feeds the carry input of the cell above it, which forms a ripple chain. A dedicated tail stage watches the top cell to derive signed overflow and the sign used for signed comparison.

A 4-bit control word picks the operation. The word carries two operand-inversion bits and a 2-bit cell selector. Inverting both operands and selecting AND gives NOR. Inverting b also forces the bottom cell's carry-in to one, so the adder forms a + ~b + 1, which is a − b. For signed less-than, the corrected sign of a − b is routed back into the bottom cell's Less input, and every other cell receives a constant zero. A zero flag reports an all-zero result, so that equality can be tested by subtraction.

Top module: `alu_ripple_top`

## Requirements
- R1: Control 4'b0000 drives result_o to the bitwise AND of a_i and b_i.
- R2: Control 4'b0001 drives result_o to the bitwise OR of a_i and b_i.
- R3: Control 4'b1100 (both inversion bits set, AND selected) drives result_o to the bitwise NOR of a_i and b_i.
- R4: Control 4'b0010 drives result_o to (a_i + b_i) mod 2^WIDTH, and carry_o to the carry out of the top bit.
- R5: Control 4'b0110 drives result_o to (a_i − b_i) mod 2^WIDTH, and carry_o to 1 exactly when a_i ≥ b_i as unsigned numbers (no borrow).
- R6: Control 4'b0111 drives result_o bit 0 to 1 exactly when a_i < b_i as two's-complement signed numbers, and all higher bits to 0. This holds even when a_i − b_i overflows.
- R7: For controls 4'b0010 and 4'b0110, overflow_o is 1 exactly when the signed result cannot be represented in WIDTH bits. This is the case when the carries into and out of the top bit differ.
- R8: For controls 4'b0000, 4'b0001, 4'b1100 and 4'b0111, overflow_o is 0.
- R9: zero_o is 1 exactly when every bit of result_o is 0. In particular, it is 1 for control 4'b0110 with equal operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| ctrl_i | input | 4 | {invert a, invert b / carry-in, select[1:0]} |
| result_o | output | WIDTH | Selected result |
| overflow_o | output | 1 | Signed overflow, for add and subtract only |
| zero_o | output | 1 | Result is all zeros |
| carry_o | output | 1 | Carry out of the top cell |

## Verification
The bench builds the unit at its default WIDTH of 32. At this width the signed boundary operands 0x7FFFFFFF, 0x80000000, −1 and 0 exercise the full 32-cell ripple path, including the cases where the top cell's carries disagree. Each of the six operations runs on every pair drawn from these corners, on random pairs and on equal pairs. That covers less-than under overflow and the zero flag after an equal-operand subtraction.

// File: rtl/alu_ctrl_pkg.sv
package alu_ctrl_pkg;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } alu_sel_e;

  typedef struct packed {
    logic     inv_a;
    logic     inv_b;
    alu_sel_e sel;
  } alu_ctrl_t;

  localparam logic [3:0] CTRL_AND = 4'b0000;
  localparam logic [3:0] CTRL_OR  = 4'b0001;
  localparam logic [3:0] CTRL_ADD = 4'b0010;
  localparam logic [3:0] CTRL_SUB = 4'b0110;
  localparam logic [3:0] CTRL_SLT = 4'b0111;
  localparam logic [3:0] CTRL_NOR = 4'b1100;

endpackage

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
  import alu_ctrl_pkg::*;
(
  input  logic     a_i,
  input  logic     b_i,
  input  logic     inv_a_i,
  input  logic     inv_b_i,
  input  logic     cin_i,
  input  logic     less_i,
  input  alu_sel_e sel_i,
  output logic     res_o,
  output logic     sum_o,
  output logic     cout_o
);

  logic a_eff;
  logic b_eff;

  assign a_eff  = a_i ^ inv_a_i;
  assign b_eff  = b_i ^ inv_b_i;
  assign sum_o  = a_eff ^ b_eff ^ cin_i;
  assign cout_o = (a_eff & b_eff) | (a_eff & cin_i) | (b_eff & cin_i);

  always_comb begin
    unique case (sel_i)
      SEL_AND:  res_o = a_eff & b_eff;
      SEL_OR:   res_o = a_eff | b_eff;
      SEL_SUM:  res_o = sum_o;
      default:  res_o = less_i;
    endcase
  end

endmodule

// File: rtl/alu_sign_tail.sv
module alu_sign_tail (
  input  logic top_sum_i,
  input  logic top_cin_i,
  input  logic top_cout_i,
  output logic ovf_o,
  output logic set_o
);

  assign ovf_o = top_cin_i ^ top_cout_i;
  assign set_o = top_sum_i ^ ovf_o;

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             zero_o
);

  assign zero_o = ~|vec_i;

endmodule

// File: rtl/alu_ripple_top.sv
module alu_ripple_top
  import alu_ctrl_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       ctrl_i,
  output logic [WIDTH-1:0] result_o,
  output logic             overflow_o,
  output logic             zero_o,
  output logic             carry_o
);

  localparam int MSB = WIDTH - 1;

  alu_ctrl_t ctrl;
  logic      ovf_raw;
  logic      set_bit;

  assign ctrl = alu_ctrl_t'(ctrl_i);

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic cin_s;
    logic less_s;
    logic res_s;
    logic sum_s;
    logic cout_s;

    if (i == 0) begin : g_lsb
      assign cin_s  = ctrl.inv_b;
      assign less_s = set_bit;
    end else begin : g_upper
      assign cin_s  = g_cell[i-1].cout_s;
      assign less_s = 1'b0;
    end

    alu_bit_cell u_cell (
      .a_i     (a_i[i]),
      .b_i     (b_i[i]),
      .inv_a_i (ctrl.inv_a),
      .inv_b_i (ctrl.inv_b),
      .cin_i   (cin_s),
      .less_i  (less_s),
      .sel_i   (ctrl.sel),
      .res_o   (res_s),
      .sum_o   (sum_s),
      .cout_o  (cout_s)
    );

    assign result_o[i] = res_s;
  end

  alu_sign_tail u_tail (
    .top_sum_i  (g_cell[MSB].sum_s),
    .top_cin_i  (g_cell[MSB].cin_s),
    .top_cout_i (g_cell[MSB].cout_s),
    .ovf_o      (ovf_raw),
    .set_o      (set_bit)
  );

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .vec_i  (result_o),
    .zero_o (zero_o)
  );

  assign carry_o    = g_cell[MSB].cout_s;
  assign overflow_o = (ctrl.sel == SEL_SUM) & ovf_raw;

  // Cross-checks between the cell column, the tail and the flag logic.
  always_comb begin
    if (ctrl_i == CTRL_ADD) begin
      p_add_sum_r4: assert (result_o == a_i + b_i)
        else $error("R4 add result mismatch");
    end
    if (ctrl_i == CTRL_SLT) begin
      p_slt_upper_zero_r6: assert (result_o[WIDTH-1:1] == '0)
        else $error("R6 upper bits nonzero");
      p_slt_signed_r6: assert (result_o[0] == ($signed(a_i) < $signed(b_i)))
        else $error("R6 signed compare wrong");
    end
    if (ctrl.sel != SEL_SUM) begin
      p_no_overflow_r8: assert (!overflow_o)
        else $error("R8 overflow on non-arithmetic op");
    end
    if (ctrl_i == CTRL_SUB && a_i == b_i) begin
      p_equal_zero_r9: assert (zero_o)
        else $error("R9 zero missing on equal subtract");
    end
  end

endmodule

// File: tb/alu_ripple_top_test.sv
module alu_ripple_top_test;

  localparam int WIDTH = 32;

  typedef struct {
    logic [WIDTH-1:0] a;
    logic [WIDTH-1:0] b;
    logic [3:0]       ctrl;
    logic [WIDTH-1:0] res;
    logic             ovf;
    logic             zero;
    logic             carry;
    logic             chk_carry;
  } exp_t;

  logic             clk;
  logic             rst_n;
  logic [WIDTH-1:0] a;
  logic [WIDTH-1:0] b;
  logic [3:0]       ctrl;
  logic [WIDTH-1:0] result;
  logic             overflow;
  logic             zero;
  logic             carry;

  int   n_checks;
  int   n_errors;
  bit   drive_done;
  exp_t sb_q[$];

  alu_ripple_top #(.WIDTH(WIDTH)) uut (
    .a_i        (a),
    .b_i        (b),
    .ctrl_i     (ctrl),
    .result_o   (result),
    .overflow_o (overflow),
    .zero_o     (zero),
    .carry_o    (carry)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b1100: return "R3";
      4'b0010: return "R4";
      4'b0110: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic exp_t model(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y,
                                 input logic [3:0] c);
    exp_t e;
    logic [WIDTH:0] s;
    e.a = x; e.b = y; e.ctrl = c;
    e.ovf = 1'b0; e.carry = 1'b0; e.chk_carry = 1'b0;
    case (c)
      4'b0000: e.res = x & y;
      4'b0001: e.res = x | y;
      4'b1100: e.res = ~(x | y);
      4'b0010: begin
        s = {1'b0, x} + {1'b0, y};
        e.res = s[WIDTH-1:0]; e.carry = s[WIDTH]; e.chk_carry = 1'b1;
        e.ovf = (x[WIDTH-1] == y[WIDTH-1]) && (e.res[WIDTH-1] != x[WIDTH-1]);
      end
      4'b0110: begin
        e.res = x - y; e.carry = (x >= y); e.chk_carry = 1'b1;
        e.ovf = (x[WIDTH-1] != y[WIDTH-1]) && (e.res[WIDTH-1] != x[WIDTH-1]);
      end
      default: e.res = {{(WIDTH-1){1'b0}}, ($signed(x) < $signed(y))};
    endcase
    e.zero = (e.res == '0);
    return e;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y,
                       input logic [3:0] c);
    @(negedge clk);
    a = x; b = y; ctrl = c;
    sb_q.push_back(model(x, y, c));
  endtask

  // Monitor: compares settled outputs one time unit after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(req_of(e.ctrl), "result", result, e.res);
        check((e.ctrl == 4'b0010 || e.ctrl == 4'b0110) ? "R7" : "R8", "overflow",
              WIDTH'(overflow), WIDTH'(e.ovf));
        check("R9", "zero", WIDTH'(zero), WIDTH'(e.zero));
        if (e.chk_carry)
          check(e.ctrl == 4'b0010 ? "R4" : "R5", "carry", WIDTH'(carry), WIDTH'(e.carry));
      end
    end
  end

  initial begin
    #800000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [WIDTH-1:0] corners [5];
    logic [3:0]       ops [6];
    corners = '{32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0001};
    ops     = '{4'b0000, 4'b0001, 4'b1100, 4'b0010, 4'b0110, 4'b0111};
    n_checks = 0; n_errors = 0; drive_done = 1'b0;
    rst_n = 1'b0; a = '0; b = '0; ctrl = 4'b0000;
    repeat (3) @(posedge clk);
    #1;
    // Idle state with zero operands and AND selected (R1, R9).
    check("R1", "idle result", result, '0);
    check("R9", "idle zero", WIDTH'(zero), WIDTH'(1));
    @(negedge clk);
    rst_n = 1'b1;
    for (int o = 0; o < 6; o++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          drive(corners[i], corners[j], ops[o]);
    for (int k = 0; k < 300; k++) begin
      logic [WIDTH-1:0] x;
      logic [WIDTH-1:0] y;
      x = $urandom;
      y = (k % 5 == 0) ? x : $urandom;
      for (int o = 0; o < 6; o++)
        drive(x, y, ops[o]);
    end
    repeat (3) @(posedge clk);
    drive_done = 1'b1;
    wait (sb_q.size() == 0);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule